// File: doc/BRIEF.md
# Four-Bit Sixteen-Operation Arithmetic/Logic Unit

This block is a purely combinational datapath element. It takes two 4-bit operands, a single carry input and a 4-bit operation code, and returns a 4-bit result together with a sign indicator. The sign indicator is the top bit of that result. A surrounding sequencer supplies the operands from its own registers and picks the operation. It then stores the result and can branch on the sign indicator. The unit holds no state.

The code space is split in two halves. Codes with a clear top bit select a bitwise logic function. Codes with the top bit set select an operand pass-through, an increment, a decrement or an addition. Every arithmetic result wraps modulo 16. The carry input is consumed only by the add-with-carry code.

Top module: `alu4_core`

## Requirements
- R1: With the operation code in 0x0..0x7, the result is, in code order: ~a, ~b, a&b, a|b, ~(a&b), ~(a|b), a^b, ~(a^b).
- R2: Code 0x8 returns a unchanged, and code 0x9 returns b unchanged.
- R3: Code 0xA returns a+1, and code 0xB returns b+1.
- R4: Code 0xC returns a-1, and code 0xD returns b-1.
- R5: Code 0xE returns a+b without regard to the carry input.
- R6: Code 0xF returns a+b+carry_in.
- R7: All arithmetic is taken modulo 16, and a carry or borrow out of bit 3 is dropped. For example, 0xF+1 gives 0x0, 0x0-1 gives 0xF, and 0xF+0xF+1 gives 0xF.
- R8: For every code other than 0xF, toggling carry_in leaves the result unchanged.
- R9: neg_flag always equals bit 3 of result.
- R10: For all 16 codes, result and neg_flag carry defined 0/1 values and respond combinationally, with no storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 4 | First operand |
| b_in | input | 4 | Second operand |
| carry_in | input | 1 | Carry input, used by code 0xF only |
| op_sel | input | 4 | Operation code |
| result | output | 4 | Operation result |
| neg_flag | output | 1 | Sign indicator, equal to result bit 3 |

## Verification
The bound checker re-evaluates a set of properties whenever the inputs change. These cover the sign indicator tracking result bit 3, the two pass-through codes, the carry-free add, the increment wrap at 0xF, and defined output values. The full logic table, the decrement and add-with-carry wrap points, and the fact that carry_in has no effect outside code 0xF are shown only by the bench. It sweeps every code against every operand pair at both carry values and compares each result with arithmetic computed independently.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

    localparam int DATA_W  = 4;
    localparam int OP_W    = 4;
    localparam int LOGIC_W = OP_W - 1;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_NOT_A  = 4'h0,
        OP_NOT_B  = 4'h1,
        OP_AND    = 4'h2,
        OP_OR     = 4'h3,
        OP_NAND   = 4'h4,
        OP_NOR    = 4'h5,
        OP_XOR    = 4'h6,
        OP_XNOR   = 4'h7,
        OP_PASS_A = 4'h8,
        OP_PASS_B = 4'h9,
        OP_INC_A  = 4'hA,
        OP_INC_B  = 4'hB,
        OP_DEC_A  = 4'hC,
        OP_DEC_B  = 4'hD,
        OP_ADD    = 4'hE,
        OP_ADC    = 4'hF
    } alu_op_e;

    typedef struct packed {
        word_t value;
        logic  sign;
    } alu_out_t;

    // Modular sum of two words plus a one-bit carry; the carry out is dropped.
    function automatic word_t wrap_sum(word_t x, word_t y, logic c);
        logic [DATA_W:0] full;
        full = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, c};
        return full[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/alu4_logic_unit.sv
module alu4_logic_unit
    import alu4_pkg::*;
(
    input  logic [LOGIC_W-1:0] fn_sel,
    input  word_t              opa,
    input  word_t              opb,
    output word_t              y
);

    // One identical lane per bit position.
    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        always_comb begin
            unique case (fn_sel)
                3'd0: y[i] = ~opa[i];
                3'd1: y[i] = ~opb[i];
                3'd2: y[i] = opa[i] & opb[i];
                3'd3: y[i] = opa[i] | opb[i];
                3'd4: y[i] = ~(opa[i] & opb[i]);
                3'd5: y[i] = ~(opa[i] | opb[i]);
                3'd6: y[i] = opa[i] ^ opb[i];
                default: y[i] = ~(opa[i] ^ opb[i]);
            endcase
        end
    end

endmodule

// File: rtl/alu4_arith_unit.sv
module alu4_arith_unit
    import alu4_pkg::*;
(
    input  alu_op_e op,
    input  word_t   opa,
    input  word_t   opb,
    input  logic    cin,
    output word_t   y
);

    word_t one_src;

    // Odd codes in the unary group act on b, even codes on a.
    assign one_src = op[0] ? opb : opa;

    always_comb begin
        unique case (op)
            OP_PASS_A, OP_PASS_B: y = one_src;
            OP_INC_A,  OP_INC_B:  y = wrap_sum(one_src, word_t'(1), 1'b0);
            OP_DEC_A,  OP_DEC_B:  y = wrap_sum(one_src, '1, 1'b0);
            OP_ADD:               y = wrap_sum(opa, opb, 1'b0);
            OP_ADC:               y = wrap_sum(opa, opb, cin);
            default:              y = '0;
        endcase
    end

endmodule

// File: rtl/alu4_core.sv
module alu4_core
    import alu4_pkg::*;
(
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic              carry_in,
    input  logic [OP_W-1:0]   op_sel,
    output logic [DATA_W-1:0] result,
    output logic              neg_flag
);

    word_t    logic_y;
    word_t    arith_y;
    alu_out_t out_s;

    alu4_logic_unit u_logic (
        .fn_sel (op_sel[LOGIC_W-1:0]),
        .opa    (a_in),
        .opb    (b_in),
        .y      (logic_y)
    );

    alu4_arith_unit u_arith (
        .op     (alu_op_e'(op_sel)),
        .opa    (a_in),
        .opb    (b_in),
        .cin    (carry_in),
        .y      (arith_y)
    );

    always_comb begin
        out_s.value = op_sel[OP_W-1] ? arith_y : logic_y;
        out_s.sign  = out_s.value[DATA_W-1];
    end

    assign result   = out_s.value;
    assign neg_flag = out_s.sign;

endmodule

// File: rtl/alu4_core_chk.sv
module alu4_core_chk (
    input logic [3:0] a_in,
    input logic [3:0] b_in,
    input logic       carry_in,
    input logic [3:0] op_sel,
    input logic [3:0] result,
    input logic       neg_flag
);

    always_comb begin
        assert_sign_msb_R9: assert (neg_flag == result[3])
            else $error("sign indicator differs from result bit 3");
    end

    always_comb begin
        assert_defined_out_R10: assert (!$isunknown({result, neg_flag}))
            else $error("undefined output value");
    end

    always_comb begin
        if (op_sel == 4'h8) begin
            assert_pass_a_R2: assert (result == a_in)
                else $error("pass-a mismatch");
        end
    end

    always_comb begin
        if (op_sel == 4'h9) begin
            assert_pass_b_R2: assert (result == b_in)
                else $error("pass-b mismatch");
        end
    end

    always_comb begin
        if (op_sel == 4'hE) begin
            assert_add_no_cin_R5: assert (result == 4'(a_in + b_in))
                else $error("carry-free add mismatch");
        end
    end

    always_comb begin
        if (op_sel == 4'hA && a_in == 4'hF) begin
            assert_inc_wrap_R7: assert (result == 4'h0)
                else $error("increment did not wrap");
        end
    end

endmodule

bind alu4_core alu4_core_chk i_alu4_core_chk (.*);

// File: tb/test_alu4_core.sv
module test_alu4_core;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic [3:0] a_in = '0;
    logic [3:0] b_in = '0;
    logic       carry_in = 1'b0;
    logic [3:0] op_sel = '0;
    logic [3:0] result;
    logic       neg_flag;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu4_core i_alu4_core (
        .a_in     (a_in),
        .b_in     (b_in),
        .carry_in (carry_in),
        .op_sel   (op_sel),
        .result   (result),
        .neg_flag (neg_flag)
    );

    function automatic int model(int op, int a, int b, int c);
        int r;
        case (op)
            0:  r = ~a;
            1:  r = ~b;
            2:  r = a & b;
            3:  r = a | b;
            4:  r = ~(a & b);
            5:  r = ~(a | b);
            6:  r = a ^ b;
            7:  r = ~(a ^ b);
            8:  r = a;
            9:  r = b;
            10: r = a + 1;
            11: r = b + 1;
            12: r = a + 15;
            13: r = b + 15;
            14: r = a + b;
            default: r = a + b + c;
        endcase
        return r & 15;
    endfunction

    function automatic string tag_of(int op);
        if (op < 8)   return "R1";
        if (op < 10)  return "R2";
        if (op < 12)  return "R3";
        if (op < 14)  return "R4";
        if (op == 14) return "R5";
        return "R6";
    endfunction

    task automatic check(string tag, int got, int exp, string what);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic apply(int op, int a, int b, int c);
        @(posedge clk);
        op_sel   = 4'(op);
        a_in     = 4'(a);
        b_in     = 4'(b);
        carry_in = c[0];
        @(negedge clk);
    endtask

    initial begin
        // Idle inputs (all zero, code 0x0) give ~0 = 0xF with the sign set.
        @(negedge clk);
        check("R1", int'(result), 15, "idle inputs");
        check("R9", int'(neg_flag), 1, "idle sign");

        // Full sweep: each code, each operand pair, both carry values.
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    int r0;
                    apply(op, a, b, 0);
                    r0 = int'(result);
                    check(tag_of(op), r0, model(op, a, b, 0), "cin=0");
                    check("R9", int'(neg_flag), (r0 >> 3) & 1, "sign cin=0");
                    check("R10", int'($isunknown({result, neg_flag})), 0, "defined");
                    apply(op, a, b, 1);
                    check(tag_of(op), int'(result), model(op, a, b, 1), "cin=1");
                    check("R9", int'(neg_flag), (int'(result) >> 3) & 1, "sign cin=1");
                    if (op != 15)
                        check("R8", int'(result), r0, "cin toggled");
                end
            end
        end

        // Wrap-around boundaries (R7).
        apply(10, 15, 0, 0);  check("R7", int'(result), 0,  "inc a 0xF");
        apply(11, 0, 15, 1);  check("R7", int'(result), 0,  "inc b 0xF");
        apply(12, 0, 0, 0);   check("R7", int'(result), 15, "dec a 0x0");
        apply(13, 3, 0, 1);   check("R7", int'(result), 15, "dec b 0x0");
        apply(14, 9, 8, 1);   check("R7", int'(result), 1,  "add 9+8");
        apply(15, 15, 15, 1); check("R7", int'(result), 15, "adc F+F+1");
        apply(15, 8, 7, 1);   check("R7", int'(result), 0,  "adc 8+7+1");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule